// File: doc/BRIEF.md
# Serial Pattern-Unlock Access Gate

This block sits beside the decoder of an asynchronous-style memory bus and guards a hidden 64-bit register, for example the value register of a timekeeping unit. The bus decoder gives the gate one strobe when a bus cycle opens and one when it closes, and it gives the direction of that cycle. At the closing strobe the gate samples the address and data bit 0. While the gate is locked, it watches consecutive write cycles and compares each sampled data bit with one bit of a fixed 64-bit key. A read cycle at any address puts the compare pointer back to the first key bit. Every access made while the gate is locked goes to memory, and this includes the writes that carry the key.

When the last key bit matches, the gate copies a parallel value into the hidden register and asserts a memory-inhibit output. The next 64 bus cycles, at any address, each move one bit between data bit 0 and the hidden register, least significant bit first. A read returns the bit at the current position and a write replaces it. After the 64th transfer the gate drops the inhibit output and returns to memory mode. A new read is then needed before any key writes count again.

Top module: `ugate_top`

## Requirements
- R1: After reset, mem_inhibit, dq0_oe, dq0_out and every bit of hid_out are 0, and the compare pointer is unarmed.
- R2: A read cycle at any address in memory mode arms the matcher and sets the compare pointer to key bit 0. A memory-mode read never drives dq0_oe and leaves dq0_out at 0.
- R3: An armed write inside the low region whose dq0_in equals KEY[pointer] moves the pointer up by one. A match at pointer 63 completes the unlock, and mem_inhibit is 1 from the clock after that cycle's closing strobe.
- R4: An armed write inside the low region whose dq0_in differs from KEY[pointer] returns the pointer to 0 and leaves the matcher armed. A retry of all 64 bits without a read then unlocks.
- R5: A write with an address at or above 0x80000 (any of bits 20..19 set) has no effect on the pointer or on the armed state while the gate is locked.
- R6: mem_inhibit stays 0 during every cycle made before the unlock completes, including all 64 key writes.
- R7: When the unlock completes, the hidden register takes the value present on hid_load at that clock.
- R8: During the transfer window, a read cycle at transfer index i drives dq0_oe = 1 and dq0_out = hidden bit i while the cycle is open. Index 0 is the least significant bit.
- R9: During the transfer window, a write cycle at transfer index i stores dq0_in into hidden bit i and keeps dq0_oe at 0. Outside the window, bus cycles never change hid_out.
- R10: After exactly 64 transfer cycles, mem_inhibit returns to 0 and the matcher is unarmed. Key writes that are not preceded by a read do not unlock.
- R11: Writes made before any read after reset do not count toward the key, even when they carry the full key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock pulse when a bus cycle opens; samples cyc_write |
| cyc_end | input | 1 | One-clock pulse when the open bus cycle closes; samples addr and dq0_in |
| cyc_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| addr | input | 21 | Bus address |
| dq0_in | input | 1 | Data bit 0 from the bus |
| hid_load | input | 64 | Parallel value copied into the hidden register at unlock |
| dq0_out | output | 1 | Hidden-register bit for a read transfer |
| dq0_oe | output | 1 | Drive enable for dq0_out during an open read transfer |
| mem_inhibit | output | 1 | Suppresses the memory access during the transfer window |
| hid_out | output | 64 | Current hidden-register contents |

## Verification
If the pointer drifts or the armed flag is lost, the unlock either never happens or happens at the wrong write, and mem_inhibit shows this on the clock right after the closing strobe of the 64th write. If the transfer index is off by one, the first read of the window returns a shifted bit of hid_load, and a window of the wrong length shows as mem_inhibit staying high or falling at the wrong cycle. If a mismatch does not reset the pointer, or an out-of-region write is counted, the retry sequences unlock too early or not at all. Both faults are visible on mem_inhibit within one bus cycle of the end of each sequence.

// File: rtl/ugate_pkg.sv
package ugate_pkg;
    // One completed bus cycle, as seen at its closing strobe
    typedef struct packed {
        logic valid;
        logic write;
        logic in_region;
        logic bit_val;
    } bus_evt_t;
endpackage

// File: rtl/ugate_cycle.sv
module ugate_cycle
    import ugate_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int REGION_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic              cyc_end,
    input  logic              cyc_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dq0_in,
    output bus_evt_t          evt,
    output logic              rd_open
);
    typedef struct packed {
        logic open;
        logic wr;
    } cyc_state_t;

    cyc_state_t cur_q, nxt_d;
    logic       hi_clear;
    logic       addr_low_unused;

    generate
        if (ADDR_W > REGION_W) begin : g_hi
            assign hi_clear        = ~|addr[ADDR_W-1:REGION_W];
            assign addr_low_unused = ^addr[REGION_W-1:0];
        end else begin : g_all
            assign hi_clear        = 1'b1;
            assign addr_low_unused = ^addr;
        end
    endgenerate

    always_comb begin
        nxt_d = cur_q;
        if (cyc_start) begin
            nxt_d.open = 1'b1;
            nxt_d.wr   = cyc_write;
        end else if (cyc_end) begin
            nxt_d.open = 1'b0;
        end
        evt.valid     = cyc_end && cur_q.open;
        evt.write     = cur_q.wr;
        evt.in_region = hi_clear;
        evt.bit_val   = dq0_in;
        rd_open       = cur_q.open && !cur_q.wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R8: a read transfer stops driving once its cycle closes
    assert_drive_ends_with_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.valid && !cyc_start) |=> !rd_open);
endmodule

// File: rtl/ugate_matcher.sv
module ugate_matcher
    import ugate_pkg::*;
#(
    parameter int               KEY_W = 64,
    parameter logic [KEY_W-1:0] KEY   = 64'hC5A3_9E1F_0B6D_72E4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  bus_evt_t evt,
    input  logic     busy,
    output logic     unlock
);
    localparam int             PW   = (KEY_W > 1) ? $clog2(KEY_W) : 1;
    localparam logic [PW-1:0]  LAST = PW'(KEY_W - 1);

    typedef struct packed {
        logic          armed;
        logic [PW-1:0] ptr;
    } match_state_t;

    match_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d  = cur_q;
        unlock = 1'b0;
        if (!busy && evt.valid) begin
            if (!evt.write) begin
                nxt_d.armed = 1'b1;
                nxt_d.ptr   = '0;
            end else if (evt.in_region && cur_q.armed) begin
                if (evt.bit_val == KEY[cur_q.ptr]) begin
                    if (cur_q.ptr == LAST) begin
                        unlock      = 1'b1;
                        nxt_d.ptr   = '0;
                        nxt_d.armed = 1'b0;
                    end else begin
                        nxt_d.ptr = cur_q.ptr + 1'b1;
                    end
                end else begin
                    nxt_d.ptr = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R5: writes above the low region leave the matcher untouched
    assert_region_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && evt.valid && evt.write && !evt.in_region) |=> ($stable(cur_q.ptr) && $stable(cur_q.armed)));

    // R2: a locked-mode read leaves the matcher armed at bit 0
    assert_read_rearms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && evt.valid && !evt.write) |=> (cur_q.armed && cur_q.ptr == '0));

    // R10: the matcher stays quiet for the whole transfer window
    assert_quiet_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cur_q));
endmodule

// File: rtl/ugate_xfer.sv
module ugate_xfer
    import ugate_pkg::*;
#(
    parameter int HID_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_evt_t         evt,
    input  logic             unlock,
    input  logic [HID_W-1:0] hid_load,
    output logic             active,
    output logic             dq_bit,
    output logic [HID_W-1:0] hid_out
);
    localparam int             IW   = (HID_W > 1) ? $clog2(HID_W) : 1;
    localparam logic [IW-1:0]  LAST = IW'(HID_W - 1);

    typedef struct packed {
        logic             active;
        logic [IW-1:0]    idx;
        logic [HID_W-1:0] hid;
    } xfer_state_t;

    xfer_state_t cur_q, nxt_d;
    logic        evt_unused;

    assign evt_unused = evt.in_region;

    always_comb begin
        nxt_d = cur_q;
        if (unlock) begin
            nxt_d.active = 1'b1;
            nxt_d.idx    = '0;
            nxt_d.hid    = hid_load;
        end else if (cur_q.active && evt.valid) begin
            if (evt.write) nxt_d.hid[cur_q.idx] = evt.bit_val;
            if (cur_q.idx == LAST) begin
                nxt_d.active = 1'b0;
                nxt_d.idx    = '0;
            end else begin
                nxt_d.idx = cur_q.idx + 1'b1;
            end
        end
        active  = cur_q.active;
        dq_bit  = cur_q.active ? cur_q.hid[cur_q.idx] : 1'b0;
        hid_out = cur_q.hid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // Independent count of transfers for the window-length check
    logic [IW:0] xfer_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                     xfer_cnt_q <= '0;
        else if (unlock)                xfer_cnt_q <= '0;
        else if (cur_q.active && evt.valid) xfer_cnt_q <= xfer_cnt_q + 1'b1;
    end

    // R10: the window closes after exactly HID_W transfers
    assert_window_length_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur_q.active) |-> (xfer_cnt_q == (IW+1)'(HID_W)));

    // R7: an unlock never arrives while a window is still open
    assert_unlock_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |-> !cur_q.active);

    // R9: outside the window the hidden register holds still
    assert_hidden_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_q.active && !unlock) |=> $stable(cur_q.hid));
endmodule

// File: rtl/ugate_top.sv
module ugate_top
    import ugate_pkg::*;
#(
    parameter int               ADDR_W   = 21,
    parameter int               REGION_W = 19,
    parameter int               KEY_W    = 64,
    parameter logic [KEY_W-1:0] KEY      = 64'hC5A3_9E1F_0B6D_72E4,
    parameter int               HID_W    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic              cyc_end,
    input  logic              cyc_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dq0_in,
    input  logic [HID_W-1:0]  hid_load,
    output logic              dq0_out,
    output logic              dq0_oe,
    output logic              mem_inhibit,
    output logic [HID_W-1:0]  hid_out
);
    bus_evt_t evt;
    logic     rd_open;
    logic     unlock;
    logic     active;
    logic     dq_bit;

    ugate_cycle #(.ADDR_W(ADDR_W), .REGION_W(REGION_W)) u_cycle (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .cyc_end   (cyc_end),
        .cyc_write (cyc_write),
        .addr      (addr),
        .dq0_in    (dq0_in),
        .evt       (evt),
        .rd_open   (rd_open)
    );

    ugate_matcher #(.KEY_W(KEY_W), .KEY(KEY)) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .busy   (active),
        .unlock (unlock)
    );

    ugate_xfer #(.HID_W(HID_W)) u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .unlock   (unlock),
        .hid_load (hid_load),
        .active   (active),
        .dq_bit   (dq_bit),
        .hid_out  (hid_out)
    );

    always_comb begin
        mem_inhibit = active;
        dq0_oe      = active && rd_open;
        dq0_out     = dq0_oe ? dq_bit : 1'b0;
    end

    // R6: the window only opens right after a low-region write completes
    assert_inhibit_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_inhibit) |-> $past(evt.valid && evt.write && evt.in_region));

    // R8: the data bit is driven only inside the transfer window
    assert_drive_inside_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dq0_oe |-> mem_inhibit);
endmodule

// File: tb/ugate_top_test.sv
module ugate_top_test;
    localparam logic [63:0] KEY_T = 64'h9D27_E04B_3C81_F65A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_start = 1'b0;
    logic        cyc_end = 1'b0;
    logic        cyc_write = 1'b0;
    logic [20:0] addr = '0;
    logic        dq0_in = 1'b0;
    logic [63:0] hid_load = '0;
    logic        dq0_out, dq0_oe, mem_inhibit;
    logic [63:0] hid_out;

    int vectors = 0;
    int miscompares = 0;
    logic s_inh, s_oe, s_dq;

    always #4 clk = ~clk;

    ugate_top #(.KEY(KEY_T)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_end(cyc_end),
        .cyc_write(cyc_write), .addr(addr), .dq0_in(dq0_in), .hid_load(hid_load),
        .dq0_out(dq0_out), .dq0_oe(dq0_oe), .mem_inhibit(mem_inhibit), .hid_out(hid_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle; samples outputs while the cycle is open
    task automatic bus_op(input logic wr, input logic [20:0] a, input logic b);
        @(negedge clk);
        cyc_start = 1'b1; cyc_write = wr; addr = a;
        @(negedge clk);
        cyc_start = 1'b0;
        s_inh = mem_inhibit; s_oe = dq0_oe; s_dq = dq0_out;
        cyc_end = 1'b1; dq0_in = b;
        @(negedge clk);
        cyc_end = 1'b0;
    endtask

    task automatic send_key(input string req);
        for (int i = 0; i < 64; i++) begin
            bus_op(1'b1, 21'h00010, KEY_T[i]);
            check({req, " R6 inhibit low during key write"}, {63'd0, s_inh}, 64'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [63:0] load1, load2, wpat, expv;
        load1 = 64'h0123_4567_89AB_CDEF;
        load2 = 64'hF0E1_D2C3_B4A5_9687;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 mem_inhibit", {63'd0, mem_inhibit}, 64'd0);
        check("R1 dq0_oe", {63'd0, dq0_oe}, 64'd0);
        check("R1 dq0_out", {63'd0, dq0_out}, 64'd0);
        check("R1 hid_out", hid_out, 64'd0);

        // R11: full key without a prior read does nothing
        hid_load = load1;
        send_key("R11");
        check("R11 no unlock before first read", {63'd0, mem_inhibit}, 64'd0);
        check("R11 hid_out unchanged", hid_out, 64'd0);

        // R2 read at a high address arms; memory-mode read never drives
        bus_op(1'b0, 21'h1F_FFFF, 1'b0);
        check("R2 memory read oe", {63'd0, s_oe}, 64'd0);
        check("R2 memory read dq", {63'd0, s_dq}, 64'd0);
        send_key("R3");
        check("R3 unlock after 64 matches", {63'd0, mem_inhibit}, 64'd1);
        check("R7 hidden loaded", hid_out, load1);

        // R8: 64 read transfers, LSB first
        hid_load = '0;
        for (int i = 0; i < 64; i++) begin
            bus_op(1'b0, 21'(i * 777), 1'b0);
            check("R8 read transfer oe", {63'd0, s_oe}, 64'd1);
            check("R8 read transfer bit", {63'd0, s_dq}, {63'd0, load1[i]});
            check("R8 inhibit during window", {63'd0, s_inh}, 64'd1);
        end
        check("R10 window closed after 64", {63'd0, mem_inhibit}, 64'd0);
        check("R9 reads kept hidden value", hid_out, load1);

        // R10: key without fresh read does not unlock
        send_key("R10");
        check("R10 unarmed after window", {63'd0, mem_inhibit}, 64'd0);

        // R4: mismatch at several positions, then retry without a read
        for (int k = 0; k < 6; k++) begin
            int p;
            p = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 17 : (k == 3) ? 40 : (k == 4) ? 62 : 63;
            bus_op(1'b0, 21'h00020, 1'b0);
            for (int i = 0; i < p; i++) bus_op(1'b1, 21'h00010, KEY_T[i]);
            bus_op(1'b1, 21'h00010, ~KEY_T[p]);
            check("R4 mismatch keeps gate locked", {63'd0, mem_inhibit}, 64'd0);
            hid_load = load2 ^ (64'd1 << p);
            send_key("R4");
            check("R4 retry unlocks", {63'd0, mem_inhibit}, 64'd1);
            check("R7 hidden loaded on retry", hid_out, load2 ^ (64'd1 << p));
            wpat = ~(KEY_T ^ (64'h1111_1111_1111_1111 << k));
            for (int i = 0; i < 64; i++) begin
                bus_op(1'b1, 21'h1A_0000, wpat[i]);
                check("R9 write transfer oe low", {63'd0, s_oe}, 64'd0);
            end
            check("R9 hidden holds written bits", hid_out, wpat);
            check("R10 window closed after writes", {63'd0, mem_inhibit}, 64'd0);
        end

        // R5: out-of-region writes with wrong bits between key bits
        hid_load = load2;
        bus_op(1'b0, 21'h18_0000, 1'b0);
        for (int i = 0; i < 64; i++) begin
            bus_op(1'b1, 21'h08_0000 | 21'(i), ~KEY_T[i]);
            check("R5 out-of-region write inhibit", {63'd0, s_inh}, 64'd0);
            bus_op(1'b1, 21'h07_FFFF, KEY_T[i]);
        end
        check("R5 unlock despite ignored writes", {63'd0, mem_inhibit}, 64'd1);

        // Mixed window: even positions written, odd positions read
        wpat = 64'hA5C3_0F96_5AE1_7B28;
        expv = '0;
        for (int i = 0; i < 64; i++) begin
            if (i % 2 == 0) begin
                bus_op(1'b1, 21'h00000, wpat[i]);
                check("R9 mixed write oe", {63'd0, s_oe}, 64'd0);
                expv[i] = wpat[i];
            end else begin
                bus_op(1'b0, 21'h1F_0000, 1'b0);
                check("R8 mixed read bit", {63'd0, s_dq}, {63'd0, load2[i]});
                expv[i] = load2[i];
            end
        end
        check("R9 mixed hidden result", hid_out, expv);
        check("R10 mixed window closed", {63'd0, mem_inhibit}, 64'd0);

        // R9: cycles outside the window leave hid_out alone
        bus_op(1'b1, 21'h00010, ~expv[0]);
        bus_op(1'b0, 21'h00010, 1'b0);
        check("R9 hidden frozen outside window", hid_out, expv);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule